// File: doc/BRIEF.md
# Idle and Standby Handshake Controller

This block sits beside the bus ports of a storage link controller and runs its low-power handshakes. On the target port it answers a system idle request with an idle acknowledge. On the initiator port it drives a standby status. Each port follows a two-bit policy held in one control register. The policy can force the low-power state, forbid it, or let the module's own activity decide. The activity-driven policy has a variant that can also raise a wakeup while the port is in its low-power state.

The block also produces a clock-stop permit for the functional clock. The permit is normally granted only while the serial link reports one of its two low-power states. An override bit in the register grants it whatever the link state, for the case where no device is attached. The block counts the initiator's outstanding transactions so that it can judge when the initiator has drained.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted, `idle_ack`, `stby`, `tgt_wake` and `ini_wake` are 0 and `cfg_rdata` reads 0x0000_0028, which is both policies at 2 and the override at 0.
- R2: A write with `cfg_we` high takes effect at the next clock edge. The target policy sits at bits 3:2, the initiator policy at bits 5:4 and the override at bit 16. All other bits read as zero and ignore writes, so writing 0xFFFF_FFFF reads back 0x0001_003C.
- R3: With target policy 0 (forced), `idle_ack` equals `sys_idle_req` one edge later, whatever `tgt_busy` is.
- R4: With target policy 1 (never), `idle_ack` is 0 one edge later and stays 0.
- R5: With target policy 2 or 3 (activity-driven), `idle_ack` rises one edge after a cycle with `sys_idle_req`=1 and `tgt_busy`=0. It then holds while the request stays high, even if busy returns. It falls one edge after the request drops.
- R6: `tgt_wake` rises one edge after `tgt_event` is seen with policy 3 while `idle_ack` is high and stays high. It then holds as a level and falls at the same edge as `idle_ack`. Under any other policy it stays 0.
- R7: With initiator policy 0, `stby` is 1 one edge later. With policy 1, it is 0 one edge later.
- R8: With initiator policy 2, `stby` is 1 one edge after a cycle in which the outstanding count (increased by `ini_issue`, decreased by `ini_done`) is zero and neither `ini_req` nor `ini_issue` is high. Otherwise it is 0.
- R9: With initiator policy 3, the rule of R8 sets `stby`. While `stby` is 1, a cycle with `ini_req` high raises `ini_wake` at the next edge. At the edge after that, `stby` and `ini_wake` both fall. `ini_wake` is never 1 while `stby` is 0.
- R10: `clk_stop_ok` is 1 exactly when the override bit is 1, or when `link_pstate` is 1 (partial) or 2 (slumber). States 0 (active) and 3 (off) do not grant it. The permit is combinational, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| sys_idle_req | input | 1 | System request for the target port to go idle |
| tgt_busy | input | 1 | Internal work or pending interrupt that blocks idle |
| tgt_event | input | 1 | Interrupt or DMA event that may wake the target port |
| idle_ack | output | 1 | Target port idle acknowledge |
| tgt_wake | output | 1 | Target-side wakeup level |
| ini_req | input | 1 | Module has a new initiator transaction pending |
| ini_issue | input | 1 | One initiator transaction issued this cycle |
| ini_done | input | 1 | One initiator transaction completed this cycle |
| stby | output | 1 | Initiator port is in standby |
| ini_wake | output | 1 | Initiator-side wakeup level |
| link_pstate | input | 2 | Link power state: 0 active, 1 partial, 2 slumber, 3 off |
| clk_stop_ok | output | 1 | Functional clock may be stopped |

## Verification
Every handshake output is a flop, so a wrong internal state shows at the ports one edge after the input that should have changed it. Examples are an acknowledge that fails to latch or drops early, and a wake level that outlives its low-power state. A drift in the outstanding-transaction counter shows later: standby asserts while transactions are still in flight, or never asserts after the last completion. Long mixed runs under every policy pair are therefore needed to expose it. A fault in the clock-stop permit is visible in the same cycle as the link-state input.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    PM_FORCE      = 2'd0,
    PM_NEVER      = 2'd1,
    PM_SMART      = 2'd2,
    PM_SMART_WAKE = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    LNK_ACTIVE  = 2'd0,
    LNK_PARTIAL = 2'd1,
    LNK_SLUMBER = 2'd2,
    LNK_OFF     = 2'd3
  } link_pwr_e;

  localparam int REG_W   = 32;
  localparam int TGT_LSB = 2;
  localparam int INI_LSB = 4;
  localparam int OVR_BIT = 16;
  localparam pm_mode_e TGT_RST = PM_SMART;
  localparam pm_mode_e INI_RST = PM_SMART;

  typedef struct packed {
    logic     ovr;
    pm_mode_e ini;
    pm_mode_e tgt;
  } lpm_cfg_t;

  // Target acknowledge for the next cycle.
  function automatic logic tgt_ack_next(pm_mode_e mode, logic req,
                                        logic busy, logic ack_q);
    logic r;
    if (mode == PM_FORCE)      r = req;
    else if (mode == PM_NEVER) r = 1'b0;
    else                       r = req && (ack_q || !busy);
    return r;
  endfunction

  // Initiator standby for the next cycle.
  function automatic logic stby_next(pm_mode_e mode, logic drained,
                                     logic sb_q, logic wake_q);
    logic r;
    if (mode == PM_FORCE)      r = 1'b1;
    else if (mode == PM_NEVER) r = 1'b0;
    else if (mode == PM_SMART) r = drained;
    else                       r = sb_q ? !wake_q : drained;
    return r;
  endfunction

  function automatic logic clk_stop_allowed(logic ovr, link_pwr_e st);
    return ovr || (st == LNK_PARTIAL) || (st == LNK_SLUMBER);
  endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output lpm_cfg_t         cfg
);

  lpm_cfg_t cfg_q;
  logic     unused_rsvd;

  assign unused_rsvd = ^{wdata[REG_W-1:OVR_BIT+1], wdata[OVR_BIT-1:INI_LSB+2],
                         wdata[TGT_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ovr <= 1'b0;
      cfg_q.ini <= INI_RST;
      cfg_q.tgt <= TGT_RST;
    end else if (we) begin
      cfg_q.ovr <= wdata[OVR_BIT];
      cfg_q.ini <= pm_mode_e'(wdata[INI_LSB+:2]);
      cfg_q.tgt <= pm_mode_e'(wdata[TGT_LSB+:2]);
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[OVR_BIT]      = cfg_q.ovr;
    rdata[INI_LSB+:2]   = cfg_q.ini;
    rdata[TGT_LSB+:2]   = cfg_q.tgt;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/lpm_tgt_side.sv
module lpm_tgt_side
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_e mode,
  input  logic     idle_req,
  input  logic     busy,
  input  logic     wake_evt,
  output logic     idle_ack,
  output logic     wake_o
);

  logic ack_d;
  logic wake_d;
  logic wake_allowed;

  assign ack_d        = tgt_ack_next(mode, idle_req, busy, idle_ack);
  assign wake_allowed = (mode == PM_SMART_WAKE) && idle_ack && ack_d;
  assign wake_d       = wake_allowed && (wake_evt || wake_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ack <= 1'b0;
      wake_o   <= 1'b0;
    end else begin
      idle_ack <= ack_d;
      wake_o   <= wake_d;
    end
  end

  AST_FORCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_FORCE) |=> (idle_ack == $past(idle_req))); // R3
  AST_NEVER_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NEVER) |=> !idle_ack); // R4
  AST_SMART_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(idle_ack) && $past(mode[1])) |-> !$past(busy)); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack); // R5
  AST_TGT_WAKE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> idle_ack); // R6

endmodule

// File: rtl/lpm_ini_side.sv
module lpm_ini_side
  import lpm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_e mode,
  input  logic     tx_req,
  input  logic     tx_issue,
  input  logic     tx_done,
  output logic     stby,
  output logic     wake_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             drained;
  logic             sb_d;
  logic             wake_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tx_issue && !tx_done)      cnt_d = cnt_q + CNT_ONE;
    else if (!tx_issue && tx_done) cnt_d = cnt_q - CNT_ONE;
  end

  assign drained = (cnt_q == '0) && !tx_req && !tx_issue;
  assign sb_d    = stby_next(mode, drained, stby, wake_o);
  assign wake_d  = (mode == PM_SMART_WAKE) && stby && sb_d && (tx_req || wake_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stby   <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stby   <= sb_d;
      wake_o <= wake_d;
    end
  end

  AST_FORCE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_FORCE) |=> stby); // R7
  AST_NEVER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NEVER) |=> !stby); // R7
  AST_STBY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stby) && $past(mode[1])) |-> ($past(cnt_q) == '0 && !$past(tx_req))); // R8
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_q == CNT_MAX && tx_issue && !tx_done)); // R8
  AST_CNT_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_q == '0 && tx_done && !tx_issue)); // R8
  AST_INI_WAKE_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> stby); // R9
  AST_INI_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && mode == PM_SMART_WAKE) |=> !stby); // R9

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int OUTST_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        sys_idle_req,
  input  logic        tgt_busy,
  input  logic        tgt_event,
  output logic        idle_ack,
  output logic        tgt_wake,
  input  logic        ini_req,
  input  logic        ini_issue,
  input  logic        ini_done,
  output logic        stby,
  output logic        ini_wake,
  input  logic [1:0]  link_pstate,
  output logic        clk_stop_ok
);

  lpm_cfg_t  cfg;
  link_pwr_e link_st;

  lpm_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  lpm_tgt_side u_tgt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg.tgt),
    .idle_req (sys_idle_req),
    .busy     (tgt_busy),
    .wake_evt (tgt_event),
    .idle_ack (idle_ack),
    .wake_o   (tgt_wake)
  );

  lpm_ini_side #(.CNT_W(OUTST_W)) u_ini (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg.ini),
    .tx_req   (ini_req),
    .tx_issue (ini_issue),
    .tx_done  (ini_done),
    .stby     (stby),
    .wake_o   (ini_wake)
  );

  assign link_st     = link_pwr_e'(link_pstate);
  assign clk_stop_ok = clk_stop_allowed(cfg.ovr, link_st);

  AST_CLKSTOP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[OVR_BIT] == 1'b0 && link_pstate == 2'd0) |-> !clk_stop_ok); // R10
  AST_CLKSTOP_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[OVR_BIT] |-> clk_stop_ok); // R10

endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;

  localparam int OW      = 4;
  localparam int CNT_TOP = (1 << OW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sys_idle_req = 1'b0, tgt_busy = 1'b0, tgt_event = 1'b0;
  logic        idle_ack, tgt_wake;
  logic        ini_req = 1'b0, ini_issue = 1'b0, ini_done = 1'b0;
  logic        stby, ini_wake;
  logic [1:0]  link_pstate = 2'd0;
  logic        clk_stop_ok;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference state
  int m_tgt = 2, m_ini = 2, m_ovr = 0;
  bit e_ack = 0, e_tw = 0, e_sb = 0, e_iw = 0;
  int e_cnt = 0;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.OUTST_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sys_idle_req(sys_idle_req), .tgt_busy(tgt_busy),
    .tgt_event(tgt_event), .idle_ack(idle_ack), .tgt_wake(tgt_wake),
    .ini_req(ini_req), .ini_issue(ini_issue), .ini_done(ini_done),
    .stby(stby), .ini_wake(ini_wake), .link_pstate(link_pstate),
    .clk_stop_ok(clk_stop_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] reg_image(int t, int i, int o);
    return (32'(o) << 16) | (32'(i) << 4) | (32'(t) << 2);
  endfunction

  // One cycle: drive at negedge, advance reference at posedge, compare at next negedge.
  task automatic step(input bit we, input logic [31:0] wd, input bit req, input bit busy,
                      input bit evt, input bit ireq, input bit iss, input bit dn);
    int  ut, ui;
    bit  n_ack, n_tw, n_sb, n_iw, drained;
    cfg_we = we; cfg_wdata = wd;
    sys_idle_req = req; tgt_busy = busy; tgt_event = evt;
    ini_req = ireq; ini_issue = iss; ini_done = dn;
    @(posedge clk);
    ut = m_tgt; ui = m_ini;
    if (ut == 0)      n_ack = req;
    else if (ut == 1) n_ack = 1'b0;
    else              n_ack = req && (e_ack || !busy);
    n_tw = (ut == 3) && e_ack && n_ack && (evt || e_tw);
    drained = (e_cnt == 0) && !ireq && !iss;
    if (ui == 0)      n_sb = 1'b1;
    else if (ui == 1) n_sb = 1'b0;
    else if (ui == 2) n_sb = drained;
    else              n_sb = e_sb ? !e_iw : drained;
    n_iw = (ui == 3) && e_sb && n_sb && (ireq || e_iw);
    e_cnt = e_cnt + int'(iss) - int'(dn);
    e_ack = n_ack; e_tw = n_tw; e_sb = n_sb; e_iw = n_iw;
    if (we) begin
      m_tgt = int'(wd[3:2]); m_ini = int'(wd[5:4]); m_ovr = int'(wd[16]);
    end
    @(negedge clk);
    check(ut == 0 ? "R3 idle_ack" : ut == 1 ? "R4 idle_ack" : "R5 idle_ack",
          32'(idle_ack), 32'(e_ack));
    check("R6 tgt_wake", 32'(tgt_wake), 32'(e_tw));
    check(ui < 2 ? "R7 stby" : ui == 2 ? "R8 stby" : "R9 stby", 32'(stby), 32'(e_sb));
    check("R9 ini_wake", 32'(ini_wake), 32'(e_iw));
    check("R2 cfg_rdata", cfg_rdata, reg_image(m_tgt, m_ini, m_ovr));
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit req;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 idle_ack", 32'(idle_ack), 32'd0);
    check("R1 stby", 32'(stby), 32'd0);
    check("R1 tgt_wake", 32'(tgt_wake), 32'd0);
    check("R1 ini_wake", 32'(ini_wake), 32'd0);
    check("R1 cfg_rdata", cfg_rdata, 32'h0000_0028);
    rst_n = 1'b1;

    // R2: reserved bits drop, fields land
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    check("R2 all-ones image", cfg_rdata, 32'h0001_003C);
    step(1, 32'h0000_0028, 0, 0, 0, 0, 0, 0);
    check("R2 restore", cfg_rdata, 32'h0000_0028);

    // R10: clock-stop permit over every link state and override value
    for (int o = 0; o < 2; o++) begin
      step(1, reg_image(2, 2, o), 0, 0, 0, 0, 0, 0);
      for (int p = 0; p < 4; p++) begin
        link_pstate = 2'(p);
        #1;
        check("R10 clk_stop_ok", 32'(clk_stop_ok), 32'((o == 1) || p == 1 || p == 2));
      end
    end
    link_pstate = 2'd0;

    // R5 directed: busy blocks, then ack holds through busy, drops on request removal
    step(1, reg_image(2, 2, 0), 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    check("R5 busy blocks ack", 32'(idle_ack), 32'd0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R5 ack after idle", 32'(idle_ack), 32'd1);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    check("R5 ack holds under busy", 32'(idle_ack), 32'd1);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check("R5 ack drops", 32'(idle_ack), 32'd0);

    // Sweep every policy pair with mixed traffic
    req = 1'b0;
    for (int ti = 0; ti < 4; ti++) begin
      for (int ii = 0; ii < 4; ii++) begin
        step(1, reg_image(ti, ii, 0), req, 0, 0, 0, 0, 0);
        for (int k = 0; k < 400; k++) begin
          bit busy, evt, ireq, iss, dn;
          if ($urandom_range(7) == 0) req = !req;
          busy = ($urandom_range(2) == 0);
          evt  = ($urandom_range(3) == 0);
          ireq = ($urandom_range(5) == 0);
          iss  = !e_sb && (e_cnt < CNT_TOP) && ($urandom_range(2) == 0);
          dn   = (e_cnt > 0) && ($urandom_range(2) == 0);
          step(0, 0, req, busy, evt, ireq, iss, dn);
        end
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule